// File: doc/BRIEF.md
# Two-Bank Register Window Decoder

This block lets a host reach a peripheral that has sixteen byte registers through an address window only eight bytes wide. The window has two banks. A single select flip-flop chooses which bank is visible. That flip-flop is bit 7 of window offset 7, and offset 7 exists in both banks. The register at offset 7 in each bank has an unused top bit, so the select can sit there without hiding any real field.

The host issues byte reads and writes with a 3-bit offset. The block turns each access into a 4-bit access toward the inner register file, or suppresses it when the offset has no register in the current bank. Strobes and data pass through combinationally. Read data is available in the same cycle, and writes land in the inner file on the clock edge that ends the cycle. The only state in the block is the select flip-flop.

Top module: `banked_reg_window`

## Requirements
- R1: After reset the select flip-flop is 0, so the low bank is visible and a read of offset 7 returns 0 in bit 7.
- R2: With the select at 0, window offsets 0 to 7 reach inner registers 0, 1, 2, 3, 11, 5, 10 and 6, in that order. Those registers are data, master control, interrupt enable, interrupt identification, receive FIFO status, receive control, transmit FIFO status and transmit control. Reads return the inner value and writes store the host byte.
- R3: With the select at 1, window offsets 1 to 7 reach inner registers 8, 9, 7, 4, 13, 14 and 15, in that order. Those registers are baud divisor low, baud divisor high, slow-clock control, carrier frequency, wakeup length, wakeup data and wakeup power/status.
- R4: A write to offset 7 loads host bit 7 into the select flip-flop on that clock edge. The same write sends host bits 6:0, with bit 7 cleared, to the offset-7 register of the bank that was selected before the write.
- R5: A read of offset 7 returns the current select in bit 7 and bits 6:0 of the selected bank's offset-7 register.
- R6: With the select at 1, offset 0 reads as 0x00, and a write to it changes no inner register.
- R7: The inner read and write strobes are asserted only during a host read or write to a mapped offset. With no host strobe, no inner strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Window offset |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read byte |
| reg_addr | output | 4 | Inner register index |
| reg_wdata | output | 8 | Inner write byte |
| reg_wr | output | 1 | Inner write strobe |
| reg_rd | output | 1 | Inner read strobe |
| reg_rdata | input | 8 | Inner read byte |

## Verification
The bench presets every inner register with bit 7 set. A decoder that passed inner bit 7 through at offset 7, or that forwarded the select bit into the inner register, would then show the wrong top bit.

Several faults would show up as a wrong inner register changing, or as a whole-file compare mismatch:
- sending an offset-7 write to the newly selected bank instead of the old one;
- swapping the two FIFO status registers;
- letting a high-bank offset-0 write reach inner register 0.

After each write the bench compares the entire inner file against its own model, so any of these is caught. Finally, idle cycles with no host strobe are checked for stray inner strobes.

// File: rtl/banked_reg_window.sv
module banked_reg_window #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  output logic [3:0]    reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  localparam int SB = DW - 1;
  localparam logic [2:0] SEL_OFS = 3'd7;

  logic bank;
  logic hit;
  logic shared;

  assign shared = (host_addr == SEL_OFS);

  always_comb begin
    hit = 1'b1;
    reg_addr = 4'd0;
    if (!bank) begin
      case (host_addr)
        3'd0: reg_addr = 4'd0;
        3'd1: reg_addr = 4'd1;
        3'd2: reg_addr = 4'd2;
        3'd3: reg_addr = 4'd3;
        3'd4: reg_addr = 4'd11;
        3'd5: reg_addr = 4'd5;
        3'd6: reg_addr = 4'd10;
        default: reg_addr = 4'd6;
      endcase
    end else begin
      case (host_addr)
        3'd0: hit = 1'b0;
        3'd1: reg_addr = 4'd8;
        3'd2: reg_addr = 4'd9;
        3'd3: reg_addr = 4'd7;
        3'd4: reg_addr = 4'd4;
        3'd5: reg_addr = 4'd13;
        3'd6: reg_addr = 4'd14;
        default: reg_addr = 4'd15;
      endcase
    end
  end

  assign reg_wr    = host_wr & hit;
  assign reg_rd    = host_rd & hit;
  assign reg_wdata = shared ? {1'b0, host_wdata[SB-1:0]} : host_wdata;

  always_comb begin
    if (!hit)        host_rdata = '0;
    else if (shared) host_rdata = {bank, reg_rdata[SB-1:0]};
    else             host_rdata = reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bank <= 1'b0;
    else if (host_wr && shared) bank <= host_wdata[SB];
  end

  p_sel_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && shared |=> bank == $past(host_wdata[SB]));

  p_sel_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && shared |-> !reg_wdata[SB]);

  p_sel_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && shared |-> host_rdata[SB] == bank);

  p_hole_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && bank && host_addr == 3'd0 |-> host_rdata == '0);

  p_hole_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && bank && host_addr == 3'd0 |-> !reg_wr);

  p_strobe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr |-> host_wr) and (reg_rd |-> host_rd));
endmodule

// File: tb/test_banked_reg_window.sv
`timescale 1ns/1ps
module test_banked_reg_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata, reg_wdata, reg_rdata;
  logic [3:0] reg_addr;
  logic reg_wr, reg_rd;

  logic [7:0] mem [16];
  logic [7:0] ref_mem [16];
  int ref_bank;
  int low_map [8]  = '{0, 1, 2, 3, 11, 5, 10, 6};
  int high_map [8] = '{-1, 8, 9, 7, 4, 13, 14, 15};
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_reg_window i_banked_reg_window (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  function automatic int target(int ofs);
    return ref_bank ? high_map[ofs] : low_map[ofs];
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic compare_file(string req);
    for (int i = 0; i < 16; i++) check(req, mem[i], ref_mem[i]);
  endtask

  task automatic host_read(string req, int ofs);
    int t;
    int exp;
    @(negedge clk);
    host_addr = 3'(ofs); host_rd = 1'b1;
    #1;
    t = target(ofs);
    if (t < 0) exp = 0;
    else if (ofs == 7) exp = (ref_bank << 7) | (ref_mem[t] & 8'h7f);
    else exp = ref_mem[t];
    check(req, host_rdata, exp);
    check({req, " rd strobe"}, reg_rd, t >= 0);
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic host_write(string req, int ofs, logic [7:0] d);
    int t;
    @(negedge clk);
    host_addr = 3'(ofs); host_wdata = d; host_wr = 1'b1;
    t = target(ofs);
    @(posedge clk); #1;
    host_wr = 1'b0;
    if (t >= 0) ref_mem[t] = (ofs == 7) ? (d & 8'h7f) : d;
    if (ofs == 7) ref_bank = d[7];
    compare_file(req);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'h80 | 8'(i * 7 + 3);
      ref_mem[i] = mem[i];
    end
    ref_bank = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    host_read("R1", 7);
    for (int o = 0; o < 7; o++) host_read("R2", o);
    for (int o = 0; o < 7; o++) host_write("R2", o, 8'(8'hc1 + o * 16));
    for (int o = 0; o < 7; o++) host_read("R2", o);

    host_write("R4", 7, 8'h95);
    host_read("R5", 7);
    for (int o = 1; o < 8; o++) host_read("R3", o);
    for (int o = 1; o < 7; o++) host_write("R3", o, 8'(8'h3a + o * 5));
    for (int o = 1; o < 7; o++) host_read("R3", o);

    host_read("R6", 0);
    host_write("R6", 0, 8'hff);
    host_read("R6", 0);

    host_write("R4", 7, 8'hea);
    host_read("R5", 7);
    host_write("R4", 7, 8'h2c);
    host_read("R5", 7);
    host_read("R2", 6);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      host_addr = 3'(k);
      #1;
      check("R7 idle wr", reg_wr, 0);
      check("R7 idle rd", reg_rd, 0);
    end
    compare_file("R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule